// File: doc/BRIEF.md
# Bit-Enabled Control Register File

This block is a compact control register file reached over a simple request and acknowledge port. A host raises a request along with a write flag, a byte address, write data and a per-bit write-enable vector. Writes complete in the cycle they are accepted. Reads return their data one cycle later. Separate stall inputs for reads and writes hold off acceptance of the pending request.

Four 32-bit registers sit at word-aligned offsets 0x0, 0x4, 0x8 and 0xC. Each field applies its own software write action. Two actions, wipe-on-write and fill-on-write, affect the whole field on any write to their register. Every other action touches only the bit positions whose enable bit is high. Bits that belong to no field read as zero.

Top module: `bitmask_regfile`

## Requirements
- R1: A write changes only bit positions whose write-enable bit is 1, except in the wipe and fill fields at 0x8. A write with an all-zero enable leaves registers 0x0, 0x4 and 0xC unchanged.
- R2: The register at 0x0 has three fields. Bits [3:0] are set-by-one with next = R | (D & S) and reset 0. Bits [7:4] are clear-by-one with next = R & ~(D & S) and reset 0xF. Bits [11:8] are toggle-by-one with next = R ^ (D & S) and reset 0.
- R3: The register at 0x4 uses the same layout and reset values with the zero-sensitive actions. Bits [3:0] use R | (~D & S). Bits [7:4] use R & (D | ~S). Bits [11:8] use R ^ (~D & S).
- R4: The register at 0xC holds a plain field in bits [7:0] with reset 0 and next = (R & ~S) | (D & S).
- R5: The register at 0x8 holds two fields. Bits [7:0] reset to 0xF0 and become 0x00 on any write. Bits [15:8] reset to 0x0F and become 0xFF on any write. Neither the data nor the enable has any effect on them.
- R6: Reset is synchronous and active high. After reset, reads return 0x0F0, 0x0F0, 0xFF0 and 0x0 for offsets 0x0, 0x4, 0x8 and 0xC.
- R7: A write request is acknowledged in the same cycle it is accepted, and only then. A write is accepted when the request is high, the write flag is high and the write stall is low.
- R8: While the stall of its own kind is high, a request is not accepted. A stalled read gives no read acknowledge, and a stalled write gives no write acknowledge and has no effect. The stall of the other kind has no influence.
- R9: An accepted read raises the read acknowledge for exactly the next cycle. In that cycle the read data holds the register's fields in their bit positions with zeros elsewhere, and the read error is 0.
- R10: An address outside the four registers, including any address with bits [1:0] not zero, reads as 0 with no error. A write to such an address is acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid |
| req_wr | input | 1 | 1 for write, 0 for read |
| addr | input | ADDR_W (6) | Byte address |
| wdata | input | 32 | Write data |
| wbiten | input | 32 | Active-high per-bit write enable |
| stall_rd | input | 1 | Holds off a pending read |
| stall_wr | input | 1 | Holds off a pending write |
| wr_ack | output | 1 | Write accepted and done this cycle |
| rd_ack | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| rd_err | output | 1 | Read error, always 0 |

## Verification
The hardest case to reach is a field whose next value depends on its earlier state and on sparse enable patterns. This covers, for example, a toggle-by-zero bit flipped twice under different enables while its neighbours stay masked. Directed writes alone rarely cover these combinations. The stimulus therefore mixes the fixed two-write sequences with a long seeded random run that biases addresses toward the mapped words and draws enables from all-ones, all-zeros and random patterns. Every write is followed at random by a read. Random stalls of both kinds, held for several cycles, show that a held-off write leaves no trace in any later read.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int RF_DW      = 32;
  localparam int NUM_REGS   = 4;
  localparam int NUM_FIELDS = 9;
  localparam int IDX_W      = $clog2(NUM_REGS);

  typedef enum logic [3:0] {
    ACT_SET1,
    ACT_CLR1,
    ACT_TOG1,
    ACT_SET0,
    ACT_CLR0,
    ACT_TOG0,
    ACT_WIPE,
    ACT_FILL,
    ACT_PLAIN
  } field_act_e;

  typedef struct packed {
    logic [IDX_W-1:0] reg_idx;
    logic [4:0]       lsb;
    logic [5:0]       width;
    field_act_e       act;
    logic [7:0]       rst_val;
  } field_cfg_t;

  // Field table: register index, position, width, write action, reset value
  function automatic field_cfg_t field_cfg(input int idx);
    field_cfg_t c;
    case (idx)
      0:       c = '{reg_idx: 2'd0, lsb: 5'd0, width: 6'd4, act: ACT_SET1,  rst_val: 8'h00};
      1:       c = '{reg_idx: 2'd0, lsb: 5'd4, width: 6'd4, act: ACT_CLR1,  rst_val: 8'h0F};
      2:       c = '{reg_idx: 2'd0, lsb: 5'd8, width: 6'd4, act: ACT_TOG1,  rst_val: 8'h00};
      3:       c = '{reg_idx: 2'd1, lsb: 5'd0, width: 6'd4, act: ACT_SET0,  rst_val: 8'h00};
      4:       c = '{reg_idx: 2'd1, lsb: 5'd4, width: 6'd4, act: ACT_CLR0,  rst_val: 8'h0F};
      5:       c = '{reg_idx: 2'd1, lsb: 5'd8, width: 6'd4, act: ACT_TOG0,  rst_val: 8'h00};
      6:       c = '{reg_idx: 2'd2, lsb: 5'd0, width: 6'd8, act: ACT_WIPE,  rst_val: 8'hF0};
      7:       c = '{reg_idx: 2'd2, lsb: 5'd8, width: 6'd8, act: ACT_FILL,  rst_val: 8'h0F};
      default: c = '{reg_idx: 2'd3, lsb: 5'd0, width: 6'd8, act: ACT_PLAIN, rst_val: 8'h00};
    endcase
    return c;
  endfunction
endpackage

// File: rtl/rf_decode.sv
module rf_decode
  import rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  localparam int UPPER_LSB = 2 + IDX_W;

  logic aligned;
  logic in_range;

  assign aligned  = (addr[1:0] == 2'b00);
  assign in_range = (addr[ADDR_W-1:UPPER_LSB] == '0);
  assign idx      = addr[UPPER_LSB-1:2];
  assign hit      = aligned && in_range;
endmodule

// File: rtl/rf_cpu_port.sv
module rf_cpu_port
  import rf_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic             req_wr,
  input  logic             stall_rd,
  input  logic             stall_wr,
  input  logic [RF_DW-1:0] rd_value,
  output logic             wr_fire,
  output logic             rd_fire,
  output logic             wr_ack,
  output logic             rd_ack,
  output logic [RF_DW-1:0] rd_data,
  output logic             rd_err
);
  assign wr_fire = req && req_wr && !stall_wr;
  assign rd_fire = req && !req_wr && !stall_rd;
  assign wr_ack  = wr_fire;
  assign rd_err  = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ack  <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_ack  <= rd_fire;
      rd_data <= rd_fire ? rd_value : '0;
    end
  end
endmodule

// File: rtl/rf_field.sv
module rf_field
  import rf_pkg::*;
#(
  parameter int         WIDTH    = 4,
  parameter field_act_e ACT      = ACT_PLAIN,
  parameter logic [7:0] RST_BYTE = 8'h00
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] d,
  input  logic [WIDTH-1:0] s,
  output logic [WIDTH-1:0] q
);
  localparam logic [WIDTH-1:0] RST_VAL = RST_BYTE[WIDTH-1:0];

  function automatic logic [WIDTH-1:0] apply_action(
    input logic [WIDTH-1:0] r,
    input logic [WIDTH-1:0] dv,
    input logic [WIDTH-1:0] sv
  );
    case (ACT)
      ACT_SET1: return r | (dv & sv);
      ACT_CLR1: return r & ~(dv & sv);
      ACT_TOG1: return r ^ (dv & sv);
      ACT_SET0: return r | (~dv & sv);
      ACT_CLR0: return r & (dv | ~sv);
      ACT_TOG0: return r ^ (~dv & sv);
      ACT_WIPE: return '0;
      ACT_FILL: return '1;
      default:  return (r & ~sv) | (dv & sv);
    endcase
  endfunction

  logic [WIDTH-1:0] q_next;
  assign q_next = apply_action(q, d, s);

  always_ff @(posedge clk) begin
    if (rst)        q <= RST_VAL;
    else if (wr_en) q <= q_next;
  end
endmodule

// File: rtl/bitmask_regfile.sv
module bitmask_regfile
  import rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [RF_DW-1:0]  wdata,
  input  logic [RF_DW-1:0]  wbiten,
  input  logic              stall_rd,
  input  logic              stall_wr,
  output logic              wr_ack,
  output logic              rd_ack,
  output logic [RF_DW-1:0]  rd_data,
  output logic              rd_err
);
  logic                                wr_fire;
  logic                                rd_fire;
  logic                                dec_hit;
  logic [IDX_W-1:0]                    dec_idx;
  logic [NUM_FIELDS-1:0][RF_DW-1:0]    field_word;
  logic [NUM_REGS-1:0][RF_DW-1:0]      reg_view;
  logic [RF_DW-1:0]                    rd_value;

  rf_decode #(.ADDR_W(ADDR_W)) u_decode (
    .addr (addr),
    .hit  (dec_hit),
    .idx  (dec_idx)
  );

  rf_cpu_port u_port (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .req_wr   (req_wr),
    .stall_rd (stall_rd),
    .stall_wr (stall_wr),
    .rd_value (rd_value),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire),
    .wr_ack   (wr_ack),
    .rd_ack   (rd_ack),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
  );

  for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
    localparam field_cfg_t CFG = field_cfg(gi);
    localparam int         LSB = int'(CFG.lsb);
    localparam int         WID = int'(CFG.width);

    logic [WID-1:0] fq;
    logic           f_wr;

    assign f_wr = wr_fire && dec_hit && (dec_idx == CFG.reg_idx);

    rf_field #(
      .WIDTH    (WID),
      .ACT      (CFG.act),
      .RST_BYTE (CFG.rst_val)
    ) u_field (
      .clk   (clk),
      .rst   (rst),
      .wr_en (f_wr),
      .d     (wdata[LSB +: WID]),
      .s     (wbiten[LSB +: WID]),
      .q     (fq)
    );

    assign field_word[gi] = RF_DW'(fq) << LSB;
  end

  always_comb begin
    reg_view = '0;
    for (int f = 0; f < NUM_FIELDS; f++) begin
      reg_view[field_cfg(f).reg_idx] = reg_view[field_cfg(f).reg_idx] | field_word[f];
    end
  end

  assign rd_value = dec_hit ? reg_view[dec_idx] : '0;
endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import rf_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           req,
  input logic                           req_wr,
  input logic [RF_DW-1:0]               wbiten,
  input logic                           stall_rd,
  input logic                           stall_wr,
  input logic                           wr_ack,
  input logic                           rd_ack,
  input logic [RF_DW-1:0]               rd_data,
  input logic                           wr_fire,
  input logic                           dec_hit,
  input logic [IDX_W-1:0]               dec_idx,
  input logic [NUM_REGS-1:0][RF_DW-1:0] reg_view
);
  assert_wr_ack_cause_R7: assert property (@(posedge clk) disable iff (rst)
    wr_ack |-> (req && req_wr && !stall_wr));

  assert_wr_ack_given_R7: assert property (@(posedge clk) disable iff (rst)
    (req && req_wr && !stall_wr) |-> wr_ack);

  assert_rd_ack_next_R9: assert property (@(posedge clk) disable iff (rst)
    (req && !req_wr && !stall_rd) |=> rd_ack);

  assert_rd_held_off_R8: assert property (@(posedge clk) disable iff (rst)
    !(req && !req_wr && !stall_rd) |=> !rd_ack);

  assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (req && !req_wr && !stall_rd && !dec_hit) |=> (rd_data == '0));

  assert_unmapped_write_inert_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && !dec_hit) |=> $stable(reg_view));

  assert_zero_enable_inert_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && dec_hit && dec_idx != 2'd2 && wbiten == '0) |=> $stable(reg_view));

  assert_wipe_fill_R5: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && dec_hit && dec_idx == 2'd2) |=> (reg_view[2][15:0] == 16'hFF00));
endmodule

bind bitmask_regfile rf_checker #(.ADDR_W(ADDR_W)) u_rf_checker (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .req_wr   (req_wr),
  .wbiten   (wbiten),
  .stall_rd (stall_rd),
  .stall_wr (stall_wr),
  .wr_ack   (wr_ack),
  .rd_ack   (rd_ack),
  .rd_data  (rd_data),
  .wr_fire  (wr_fire),
  .dec_hit  (dec_hit),
  .dec_idx  (dec_idx),
  .reg_view (reg_view)
);

// File: tb/bitmask_regfile_bench.sv
module bitmask_regfile_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic        req_wr = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] wbiten = '0;
  logic        stall_rd = 1'b0;
  logic        stall_wr = 1'b0;
  logic        wr_ack;
  logic        rd_ack;
  logic [31:0] rd_data;
  logic        rd_err;

  int total = 0;
  int fails = 0;
  logic [31:0] model [4];

  bitmask_regfile u_bitmask_regfile (
    .clk(clk), .rst(rst), .req(req), .req_wr(req_wr), .addr(addr),
    .wdata(wdata), .wbiten(wbiten), .stall_rd(stall_rd), .stall_wr(stall_wr),
    .wr_ack(wr_ack), .rd_ack(rd_ack), .rd_data(rd_data), .rd_err(rd_err)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit is_mapped(input logic [5:0] a);
    return (a[1:0] == 2'b00) && (a[5:4] == 2'b00);
  endfunction

  // Bit-by-bit restatement of each field's write action
  function automatic logic [31:0] model_write(input int r, input logic [31:0] old,
                                              input logic [31:0] d, input logic [31:0] s);
    logic [31:0] n = old;
    for (int b = 0; b < 16; b++) begin
      case (r)
        0: if (b < 12 && s[b] && d[b]) begin
             if (b < 4) n[b] = 1'b1; else if (b < 8) n[b] = 1'b0; else n[b] = ~old[b];
           end
        1: if (b < 12 && s[b] && !d[b]) begin
             if (b < 4) n[b] = 1'b1; else if (b < 8) n[b] = 1'b0; else n[b] = ~old[b];
           end
        2: n[b] = (b >= 8);
        default: if (b < 8 && s[b]) n[b] = d[b];
      endcase
    end
    return n;
  endfunction

  task automatic model_reset();
    model[0] = 32'h0F0; model[1] = 32'h0F0; model[2] = 32'hFF0; model[3] = 32'h0;
  endtask

  task automatic do_write(input logic [5:0] a, input logic [31:0] d, input logic [31:0] s,
                          input int n_stall, input bit other_stall);
    @(negedge clk);
    req = 1'b1; req_wr = 1'b1; addr = a; wdata = d; wbiten = s;
    stall_wr = (n_stall > 0); stall_rd = other_stall;
    #1 chk("R7/R8 write ack", {31'b0, wr_ack}, {31'b0, n_stall == 0});
    for (int k = 0; k < n_stall; k++) begin
      @(negedge clk);
      if (k == n_stall - 1) stall_wr = 1'b0;
      #1 chk("R8 stalled write ack", {31'b0, wr_ack}, {31'b0, k == n_stall - 1});
    end
    @(negedge clk);
    req = 1'b0; req_wr = 1'b0; stall_rd = 1'b0;
    if (is_mapped(a)) model[a[3:2]] = model_write(int'(a[3:2]), model[a[3:2]], d, s);
  endtask

  task automatic do_read(input logic [5:0] a, input string tag, input int n_stall,
                         input bit other_stall);
    logic [31:0] exp;
    @(negedge clk);
    req = 1'b1; req_wr = 1'b0; addr = a;
    stall_rd = (n_stall > 0); stall_wr = other_stall;
    for (int k = 0; k < n_stall; k++) begin
      @(negedge clk);
      chk("R8 stalled read ack", {31'b0, rd_ack}, 32'h0);
      if (k == n_stall - 1) stall_rd = 1'b0;
    end
    @(negedge clk);
    req = 1'b0; stall_wr = 1'b0;
    exp = is_mapped(a) ? model[a[3:2]] : 32'h0;
    chk("R9 read ack", {31'b0, rd_ack}, 32'h1);
    chk("R9 read err", {31'b0, rd_err}, 32'h0);
    chk(tag, rd_data, exp);
    @(negedge clk);
    chk("R9 ack one cycle", {31'b0, rd_ack}, 32'h0);
  endtask

  task automatic direct_read(input logic [5:0] a, input logic [31:0] exp, input string tag);
    do_read(a, tag, 0, 1'b0);
    chk({tag, " literal"}, model[a[3:2]] & {32{is_mapped(a)}}, exp);
  endtask

  initial begin
    model_reset();
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6 reset values
    direct_read(6'h00, 32'h0F0, "R6 reset 0x0");
    direct_read(6'h04, 32'h0F0, "R6 reset 0x4");
    direct_read(6'h08, 32'hFF0, "R6 reset 0x8");
    direct_read(6'h0C, 32'h000, "R6 reset 0xC");
    // R2 write-one actions
    do_write(6'h00, 32'h555, 32'h333, 0, 1'b0);
    direct_read(6'h00, 32'h1E1, "R2 first");
    do_write(6'h00, 32'h5AA, 32'h333, 0, 1'b0);
    direct_read(6'h00, 32'h0C3, "R2 second");
    // R3 write-zero actions
    do_write(6'h04, 32'hAAA, 32'h333, 0, 1'b0);
    direct_read(6'h04, 32'h1E1, "R3 first");
    do_write(6'h04, 32'hA55, 32'h333, 0, 1'b0);
    direct_read(6'h04, 32'h0C3, "R3 second");
    // R5 wipe/fill ignores data and enable
    do_write(6'h08, 32'h1234, 32'hFF00, 0, 1'b0);
    direct_read(6'h08, 32'hFF00, "R5 wipe fill");
    // R4 plain field
    do_write(6'h0C, 32'hFF, 32'hF0, 0, 1'b0);
    direct_read(6'h0C, 32'hF0, "R4 plain a");
    do_write(6'h0C, 32'h00, 32'h3C, 0, 1'b0);
    direct_read(6'h0C, 32'hC0, "R4 plain b");
    // R1 zero enable leaves state
    do_write(6'h00, 32'hFFFF_FFFF, 32'h0, 0, 1'b0);
    direct_read(6'h00, 32'h0C3, "R1 zero enable");
    // R10 unmapped and misaligned
    do_write(6'h10, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 1'b0);
    do_write(6'h0D, 32'h0, 32'hFFFF_FFFF, 0, 1'b0);
    direct_read(6'h0C, 32'hC0, "R10 unmapped write inert");
    direct_read(6'h14, 32'h0, "R10 unmapped read");
    direct_read(6'h01, 32'h0, "R10 misaligned read");
    // R8 stalled write followed by stalled read, other stall held
    do_write(6'h0C, 32'h11, 32'hFF, 3, 1'b1);
    do_read(6'h0C, "R8 stalled read data", 2, 1'b1);
    // R1 R2 R3 R4 R5 random mix
    for (int i = 0; i < 400; i++) begin
      logic [5:0]  a;
      logic [31:0] s;
      int          w = ($urandom % 4 == 0) ? int'($urandom % 16) : int'($urandom % 4);
      a = 6'(w * 4);
      if ($urandom % 10 == 0) a = a | 6'(1 + $urandom % 3);
      case ($urandom % 4)
        0:       s = 32'hFFFF_FFFF;
        1:       s = 32'h0;
        default: s = $urandom;
      endcase
      do_write(a, $urandom, s, int'($urandom % 3) * int'($urandom % 2), 1'($urandom));
      if ($urandom % 2 == 0)
        do_read(a, "R1 random readback", int'($urandom % 3) * int'($urandom % 2), 1'($urandom));
    end
    for (int r = 0; r < 4; r++) do_read(6'(r * 4), "R1 final sweep", 0, 1'b0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule